// File: doc/BRIEF.md
# JTAG Instruction Register with Status Capture

This block is a complete JTAG test access port. A sixteen-state controller advances on every rising edge of the test clock according to the mode-select input. It drives a 5-bit instruction register and chooses which data register sits between the serial input and the serial output. The internal data registers are a 32-bit identification code, a 32-bit user code and a one-bit bypass stage. The boundary-scan chain lives outside this block: a select output enables it and a return input carries its serial data back.

When the instruction path is captured, the shift stage does not load the current instruction. It loads a fixed status word instead. The two lowest bits are always 1 and 0. The upper three bits are the inverse of three sticky error flags: the TDO-path fault, the probe-A fault and the probe-B fault. A flag is set whenever its active-low fault input is sampled low. All flags clear when the controller executes Update-IR or is reset.

A security-lock input turns off the two private instructions, probe and program. While locked, those codes behave like bypass. The public instructions keep working as normal.

Top module: `tap_status_ir`

## Requirements
- R1: While `trst_n` is low, the controller is in Test-Logic-Reset, `tdo_oe` and `tdo` are 0, and the error flags are cleared. Leaving reset, the active instruction is the identification code (5'b00001), so a data scan with no instruction load returns the identification value.
- R2: The controller follows the standard sixteen-state JTAG graph on rising `tck`. Five consecutive rising edges with `tms` high reach Test-Logic-Reset from any state. That state reloads the identification instruction.
- R3: On the edge that leaves Capture-IR, the instruction shift stage loads the following: bit0 = 1, bit1 = 0, bit2 = not TDO-fault flag, bit3 = not probe-A flag, bit4 = not probe-B flag. With no errors pending, the first five bits seen on `tdo` in Shift-IR are 1,0,1,1,1 (5'b11101 read LSB first).
- R4: `fault_n[0]` (TDO path), `fault_n[1]` (probe A) and `fault_n[2]` (probe B) are active low. Sampling one low for a single rising edge sets its flag, and the flag stays set until it is cleared. A fault that is low exactly on the Capture-IR edge is already visible in the captured word.
- R5: Flags clear on the edge that executes Update-IR and on `trst_n`. A fault input that is low on that same Update-IR edge leaves its flag set.
- R6: Every data register shifts with its MSB nearest `tdi` and its LSB driving `tdo`. The identification register captures `IDCODE_VAL` with bit 0 forced to 1.
- R7: The user-code instruction (5'b00010) captures the 32-bit `ucode` input. Bits that are unprogrammed (0 on the input) read as 0.
- R8: The bypass instruction (5'b11111) and every undefined code select a one-bit register. That register captures 0 and delays `tdi` by one shift.
- R9: EXTEST (5'b00000) and SAMPLE (5'b00011) raise `bsr_sel`, and Shift-DR then passes `bsr_ret` to `tdo`.
- R10: Probe (5'b10000) raises `probe_en` and program (5'b10001) raises `prog_en`, each only while `sec_lock` is low. While `sec_lock` is high, both codes act as bypass, and the public instructions are unaffected.
- R11: `tdo` and `tdo_oe` change only on falling `tck`. `tdo_oe` is high exactly while the controller is in Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling tck |
| tdo_oe | output | 1 | Output enable for tdo; high only while shifting |
| fault_n | input | 3 | Active-low error inputs: [0] TDO path, [1] probe A, [2] probe B |
| sec_lock | input | 1 | Security lock; blocks the probe and program instructions |
| ucode | input | 32 | Programmed user code; unprogrammed bits are 0 |
| bsr_sel | output | 1 | Selects the external boundary-scan chain |
| bsr_ret | input | 1 | Serial return from the boundary-scan chain |
| probe_en | output | 1 | Probe instruction active and not locked |
| prog_en | output | 1 | Program instruction active and not locked |

## Verification
Two pairs of functions can meet on one rising edge. In the first, a fault first appears on the same edge that captures the status word. In the second, a fault appears on the same edge that clears the flags at Update-IR. The bench drives a fault input low only during the single step that leaves Capture-IR, or only during the step that leaves Update-IR. It then judges the result from the serially shifted status word: the first case must show the fault in that same capture, and the second must show it in the next capture, after which a further capture must read clean.

// File: rtl/tapsi_pkg.sv
`timescale 1ns/1ps
package tapsi_pkg;

   typedef enum logic [3:0] {
      ST_TLR, ST_RTI,
      ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
      ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
   } tap_st_e;

   typedef enum logic [1:0] {
      SRC_BYP, SRC_ID, SRC_UC, SRC_BSR
   } dr_src_e;

   localparam int OPC_W = 5;
   localparam logic [OPC_W-1:0] OP_EXTEST = 5'b00000;
   localparam logic [OPC_W-1:0] OP_IDCODE = 5'b00001;
   localparam logic [OPC_W-1:0] OP_UCODE  = 5'b00010;
   localparam logic [OPC_W-1:0] OP_SAMPLE = 5'b00011;
   localparam logic [OPC_W-1:0] OP_PROBE  = 5'b10000;
   localparam logic [OPC_W-1:0] OP_PROG   = 5'b10001;
   localparam logic [OPC_W-1:0] OP_BYPASS = 5'b11111;

   function automatic tap_st_e tap_next(input tap_st_e s, input logic m);
      case (s)
         ST_TLR:    return m ? ST_TLR    : ST_RTI;
         ST_RTI:    return m ? ST_SEL_DR : ST_RTI;
         ST_SEL_DR: return m ? ST_SEL_IR : ST_CAP_DR;
         ST_CAP_DR: return m ? ST_EX1_DR : ST_SH_DR;
         ST_SH_DR:  return m ? ST_EX1_DR : ST_SH_DR;
         ST_EX1_DR: return m ? ST_UPD_DR : ST_PAU_DR;
         ST_PAU_DR: return m ? ST_EX2_DR : ST_PAU_DR;
         ST_EX2_DR: return m ? ST_UPD_DR : ST_SH_DR;
         ST_UPD_DR: return m ? ST_SEL_DR : ST_RTI;
         ST_SEL_IR: return m ? ST_TLR    : ST_CAP_IR;
         ST_CAP_IR: return m ? ST_EX1_IR : ST_SH_IR;
         ST_SH_IR:  return m ? ST_EX1_IR : ST_SH_IR;
         ST_EX1_IR: return m ? ST_UPD_IR : ST_PAU_IR;
         ST_PAU_IR: return m ? ST_EX2_IR : ST_PAU_IR;
         ST_EX2_IR: return m ? ST_UPD_IR : ST_SH_IR;
         ST_UPD_IR: return m ? ST_SEL_DR : ST_RTI;
         default:   return ST_TLR;
      endcase
   endfunction

endpackage

// File: rtl/tapsi_ctrl.sv
`timescale 1ns/1ps
module tapsi_ctrl
   import tapsi_pkg::*;
(
   input  logic    tck,
   input  logic    trst_n,
   input  logic    tms,
   output tap_st_e st
);

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) st <= ST_TLR;
      else         st <= tap_next(st, tms);
   end

   // checker: run of consecutive tms-high edges, saturating at five
   logic [2:0] ones_cnt;
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)               ones_cnt <= 3'd0;
      else if (!tms)             ones_cnt <= 3'd0;
      else if (ones_cnt != 3'd5) ones_cnt <= ones_cnt + 3'd1;
   end

   p_five_ones_r2: assert property (@(posedge tck) disable iff (!trst_n)
      (ones_cnt == 3'd5) |-> (st == ST_TLR));

endmodule

// File: rtl/tapsi_ir.sv
`timescale 1ns/1ps
module tapsi_ir
   import tapsi_pkg::*;
#(
   parameter int IR_W  = 5,
   parameter int N_FLT = 3
)(
   input  logic             tck,
   input  logic             trst_n,
   input  tap_st_e          st,
   input  logic             tdi,
   input  logic [N_FLT-1:0] fault_n,
   output logic [IR_W-1:0]  ir_q,
   output logic             ir_lsb
);

   localparam int FIX_W = IR_W - N_FLT;
   localparam logic [FIX_W-1:0] FIX_PAT = FIX_W'(1);

   if (FIX_W < 1) begin : g_bad_split
      $error("tapsi_ir: instruction width must exceed the flag count");
   end

   logic [N_FLT-1:0] flags;
   logic [N_FLT-1:0] live;
   logic [IR_W-1:0]  ir_sh;
   logic             clr_now;

   assign live    = ~fault_n;
   assign clr_now = (st == ST_UPD_IR) || (st == ST_TLR);

   // sticky flags: a fault seen on the clearing edge still sets its flag
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)      flags <= '0;
      else if (clr_now) flags <= live;
      else              flags <= flags | live;
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         ir_sh <= '0;
      end else if (st == ST_CAP_IR) begin
         ir_sh <= {~(flags | live), FIX_PAT};
      end else if (st == ST_SH_IR) begin
         ir_sh <= {tdi, ir_sh[IR_W-1:1]};
      end
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)              ir_q <= IR_W'(OP_IDCODE);
      else if (st == ST_TLR)    ir_q <= IR_W'(OP_IDCODE);
      else if (st == ST_UPD_IR) ir_q <= ir_sh;
   end

   assign ir_lsb = ir_sh[0];

   p_capture_fixed_r3: assert property (@(posedge tck) disable iff (!trst_n)
      (st == ST_CAP_IR) |=> (ir_sh[FIX_W-1:0] == FIX_PAT));

   p_flag_sticky_r4: assert property (@(posedge tck) disable iff (!trst_n)
      (st != ST_UPD_IR && st != ST_TLR) |=> ((flags & $past(flags)) == $past(flags)));

   p_flag_clear_r5: assert property (@(posedge tck) disable iff (!trst_n)
      (st == ST_UPD_IR && fault_n == '1) |=> (flags == '0));

   p_ir_tlr_r1: assert property (@(posedge tck) disable iff (!trst_n)
      (st == ST_TLR) |=> (ir_q == IR_W'(OP_IDCODE)));

endmodule

// File: rtl/tapsi_decode.sv
`timescale 1ns/1ps
module tapsi_decode
   import tapsi_pkg::*;
#(
   parameter int IR_W = 5
)(
   input  logic [IR_W-1:0] ir_q,
   input  logic            sec_lock,
   output dr_src_e         src,
   output logic            bsr_sel,
   output logic            probe_en,
   output logic            prog_en
);

   always_comb begin
      src      = SRC_BYP;
      bsr_sel  = 1'b0;
      probe_en = 1'b0;
      prog_en  = 1'b0;
      case (ir_q)
         IR_W'(OP_IDCODE): src = SRC_ID;
         IR_W'(OP_UCODE):  src = SRC_UC;
         IR_W'(OP_EXTEST),
         IR_W'(OP_SAMPLE): begin
            src     = SRC_BSR;
            bsr_sel = 1'b1;
         end
         IR_W'(OP_PROBE):  probe_en = !sec_lock;
         IR_W'(OP_PROG):   prog_en  = !sec_lock;
         default:          src = SRC_BYP;
      endcase
   end

endmodule

// File: rtl/tapsi_dr.sv
`timescale 1ns/1ps
module tapsi_dr
   import tapsi_pkg::*;
#(
   parameter int              DR_W       = 32,
   parameter logic [DR_W-1:0] IDCODE_VAL = '0
)(
   input  logic            tck,
   input  logic            trst_n,
   input  tap_st_e         st,
   input  dr_src_e         src,
   input  logic            tdi,
   input  logic [DR_W-1:0] ucode,
   output logic            dr_lsb
);

   localparam logic [DR_W-1:0] ID_CAP = {IDCODE_VAL[DR_W-1:1], 1'b1};

   logic [DR_W-1:0] word_sh;
   logic            byp_q;
   logic            use_word;

   assign use_word = (src == SRC_ID) || (src == SRC_UC);

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         word_sh <= '0;
      end else if (use_word && st == ST_CAP_DR) begin
         word_sh <= (src == SRC_ID) ? ID_CAP : ucode;
      end else if (use_word && st == ST_SH_DR) begin
         word_sh <= {tdi, word_sh[DR_W-1:1]};
      end
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)               byp_q <= 1'b0;
      else if (st == ST_CAP_DR)  byp_q <= 1'b0;
      else if (st == ST_SH_DR)   byp_q <= tdi;
   end

   assign dr_lsb = use_word ? word_sh[0] : byp_q;

   p_byp_capture_r8: assert property (@(posedge tck) disable iff (!trst_n)
      (st == ST_CAP_DR) |=> (byp_q == 1'b0));

endmodule

// File: rtl/tap_status_ir.sv
`timescale 1ns/1ps
module tap_status_ir
   import tapsi_pkg::*;
#(
   parameter int              IR_W       = 5,
   parameter int              N_FLT      = 3,
   parameter int              DR_W       = 32,
   parameter logic [DR_W-1:0] IDCODE_VAL = 32'h4A61_7E30
)(
   input  logic             tck,
   input  logic             trst_n,
   input  logic             tms,
   input  logic             tdi,
   output logic             tdo,
   output logic             tdo_oe,
   input  logic [N_FLT-1:0] fault_n,
   input  logic             sec_lock,
   input  logic [DR_W-1:0]  ucode,
   output logic             bsr_sel,
   input  logic             bsr_ret,
   output logic             probe_en,
   output logic             prog_en
);

   if (IR_W != OPC_W) begin : g_bad_ir
      $error("tap_status_ir: instruction width must match the opcode width");
   end
   if (DR_W < 2) begin : g_bad_dr
      $error("tap_status_ir: data register width too small");
   end

   tap_st_e         st;
   logic [IR_W-1:0] ir_q;
   logic            ir_lsb;
   logic            dr_lsb;
   dr_src_e         src;
   logic            dr_bit;
   logic            shifting;

   tapsi_ctrl u_ctrl (
      .tck    (tck),
      .trst_n (trst_n),
      .tms    (tms),
      .st     (st)
   );

   tapsi_ir #(.IR_W(IR_W), .N_FLT(N_FLT)) u_ir (
      .tck     (tck),
      .trst_n  (trst_n),
      .st      (st),
      .tdi     (tdi),
      .fault_n (fault_n),
      .ir_q    (ir_q),
      .ir_lsb  (ir_lsb)
   );

   tapsi_decode #(.IR_W(IR_W)) u_dec (
      .ir_q     (ir_q),
      .sec_lock (sec_lock),
      .src      (src),
      .bsr_sel  (bsr_sel),
      .probe_en (probe_en),
      .prog_en  (prog_en)
   );

   tapsi_dr #(.DR_W(DR_W), .IDCODE_VAL(IDCODE_VAL)) u_dr (
      .tck    (tck),
      .trst_n (trst_n),
      .st     (st),
      .src    (src),
      .tdi    (tdi),
      .ucode  (ucode),
      .dr_lsb (dr_lsb)
   );

   assign dr_bit   = (src == SRC_BSR) ? bsr_ret : dr_lsb;
   assign shifting = (st == ST_SH_IR) || (st == ST_SH_DR);

   // serial output retimed to the falling edge
   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n) begin
         tdo    <= 1'b0;
         tdo_oe <= 1'b0;
      end else begin
         tdo_oe <= shifting;
         if (st == ST_SH_IR)      tdo <= ir_lsb;
         else if (st == ST_SH_DR) tdo <= dr_bit;
         else                     tdo <= 1'b0;
      end
   end

   p_oe_shift_r11: assert property (@(posedge tck) disable iff (!trst_n)
      tdo_oe |-> (st == ST_SH_IR || st == ST_SH_DR));

   p_lock_private_r10: assert property (@(posedge tck) disable iff (!trst_n)
      sec_lock |-> !(probe_en || prog_en));

endmodule

// File: tb/tap_status_ir_bench.sv
`timescale 1ns/1ps
module tap_status_ir_bench;

   localparam logic [31:0] ID_PARAM = 32'h4A61_7E30;
   localparam logic [31:0] ID_EXP   = ID_PARAM | 32'h1;
   localparam logic [4:0]  CAP_OK   = 5'b11101;
   localparam int          NVEC     = 11;

   // vector: {opcode[4:0], lock, kind[1:0] (0 byp,1 id,2 user,3 bsr), probe, prog, bsr}
   localparam logic [10:0] VEC [NVEC] = '{
      {5'b00001, 1'b0, 2'd1, 3'b000},
      {5'b00010, 1'b0, 2'd2, 3'b000},
      {5'b11111, 1'b0, 2'd0, 3'b000},
      {5'b01010, 1'b0, 2'd0, 3'b000},
      {5'b00000, 1'b0, 2'd3, 3'b001},
      {5'b00011, 1'b1, 2'd3, 3'b001},
      {5'b10000, 1'b0, 2'd0, 3'b100},
      {5'b10001, 1'b0, 2'd0, 3'b010},
      {5'b10000, 1'b1, 2'd0, 3'b000},
      {5'b10001, 1'b1, 2'd0, 3'b000},
      {5'b00010, 1'b1, 2'd2, 3'b000}
   };

   logic        tck = 1'b0;
   logic        trst_n = 1'b0;
   logic        tms = 1'b1;
   logic        tdi = 1'b0;
   logic        tdo;
   logic        tdo_oe;
   logic [2:0]  fault_n = 3'b111;
   logic        sec_lock = 1'b0;
   logic [31:0] ucode = 32'h8001_0420;
   logic        bsr_sel;
   logic        bsr_ret = 1'b1;
   logic        probe_en;
   logic        prog_en;

   int n_chk = 0;
   int n_bad = 0;
   int oe_bad = 0;
   bit done = 1'b0;

   always #2.5 tck = ~tck;

   tap_status_ir #(.IDCODE_VAL(ID_PARAM)) u_tap_status_ir (
      .tck      (tck),
      .trst_n   (trst_n),
      .tms      (tms),
      .tdi      (tdi),
      .tdo      (tdo),
      .tdo_oe   (tdo_oe),
      .fault_n  (fault_n),
      .sec_lock (sec_lock),
      .ucode    (ucode),
      .bsr_sel  (bsr_sel),
      .bsr_ret  (bsr_ret),
      .probe_en (probe_en),
      .prog_en  (prog_en)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input logic m, input logic d);
      tms = m;
      tdi = d;
      @(posedge tck);
      @(negedge tck);
      #0.5;
   endtask

   task automatic load_ir(input logic [4:0] op, input logic [2:0] cap_err,
                          input logic [2:0] upd_err, output logic [4:0] dout);
      step(1'b1, 1'b0);
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
      fault_n = ~cap_err;
      step(1'b0, 1'b0);
      fault_n = 3'b111;
      for (int i = 0; i < 5; i++) begin
         dout[i] = tdo;
         if (!tdo_oe) oe_bad++;
         step(logic'(i == 4), op[i]);
      end
      step(1'b1, 1'b0);
      fault_n = ~upd_err;
      step(1'b0, 1'b0);
      fault_n = 3'b111;
   endtask

   task automatic scan_dr(input logic [31:0] din, output logic [31:0] dout);
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
      step(1'b0, 1'b0);
      for (int i = 0; i < 32; i++) begin
         dout[i] = tdo;
         if (!tdo_oe) oe_bad++;
         step(logic'(i == 31), din[i]);
      end
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
   endtask

   task automatic pulse_fault(input logic [2:0] e);
      fault_n = ~e;
      step(1'b0, 1'b0);
      fault_n = 3'b111;
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [4:0]  irv;
      logic [31:0] drv;
      logic [31:0] din;
      logic [31:0] exp;

      repeat (3) @(negedge tck);
      #0.5;
      chk("R1 reset oe", {31'b0, tdo_oe}, 32'd0);
      chk("R11 reset tdo", {31'b0, tdo}, 32'd0);
      trst_n = 1'b1;
      step(1'b0, 1'b0);
      chk("R11 oe low in idle", {31'b0, tdo_oe}, 32'd0);

      scan_dr(32'h0F0F_3C3C, drv);
      chk("R1 idcode after reset", drv, ID_EXP);

      // table walk
      for (int v = 0; v < NVEC; v++) begin
         sec_lock = VEC[v][5];
         load_ir(VEC[v][10:6], 3'b000, 3'b000, irv);
         chk("R3 capture pattern", {27'b0, irv}, {27'b0, CAP_OK});
         chk("R10 probe_en", {31'b0, probe_en}, {31'b0, VEC[v][2]});
         chk("R10 prog_en", {31'b0, prog_en}, {31'b0, VEC[v][1]});
         chk("R9 bsr_sel", {31'b0, bsr_sel}, {31'b0, VEC[v][0]});
         din = 32'hA5C3_0F96 ^ (32'h1111_1111 * v);
         scan_dr(din, drv);
         case (VEC[v][4:3])
            2'd1:    exp = ID_EXP;
            2'd2:    exp = ucode;
            2'd3:    exp = 32'hFFFF_FFFF;
            default: exp = {din[30:0], 1'b0};
         endcase
         case (VEC[v][4:3])
            2'd1:    chk("R6 idcode scan", drv, exp);
            2'd2:    chk("R7 usercode scan", drv, exp);
            2'd3:    chk("R9 boundary return", drv, exp);
            default: chk("R8 bypass scan", drv, exp);
         endcase
      end
      sec_lock = 1'b0;

      // unprogrammed user code reads zero
      ucode = 32'h0;
      load_ir(5'b00010, 3'b000, 3'b000, irv);
      scan_dr(32'hFFFF_FFFF, drv);
      chk("R7 unprogrammed usercode", drv, 32'h0);

      // sticky single fault, then cleared by update
      pulse_fault(3'b010);
      load_ir(5'b11111, 3'b000, 3'b000, irv);
      chk("R4 sticky probe-A flag", {27'b0, irv}, {27'b0, 5'b10101});
      load_ir(5'b11111, 3'b000, 3'b000, irv);
      chk("R5 cleared by update", {27'b0, irv}, {27'b0, CAP_OK});

      // all three faults at once
      pulse_fault(3'b111);
      load_ir(5'b11111, 3'b000, 3'b000, irv);
      chk("R4 three flags", {27'b0, irv}, {27'b0, 5'b00001});
      load_ir(5'b11111, 3'b000, 3'b000, irv);
      chk("R5 three cleared", {27'b0, irv}, {27'b0, CAP_OK});

      // fault only on the capture edge
      load_ir(5'b11111, 3'b001, 3'b000, irv);
      chk("R4 fault on capture edge", {27'b0, irv}, {27'b0, 5'b11001});
      load_ir(5'b11111, 3'b000, 3'b000, irv);
      chk("R5 capture-edge fault cleared", {27'b0, irv}, {27'b0, CAP_OK});

      // fault only on the update edge: survives the clear
      load_ir(5'b11111, 3'b000, 3'b100, irv);
      chk("R5 update edge clean capture", {27'b0, irv}, {27'b0, CAP_OK});
      load_ir(5'b11111, 3'b000, 3'b000, irv);
      chk("R5 fault on update edge kept", {27'b0, irv}, {27'b0, 5'b01101});
      load_ir(5'b11111, 3'b000, 3'b000, irv);
      chk("R5 update-edge fault cleared", {27'b0, irv}, {27'b0, CAP_OK});

      // trst clears flags and restores identification instruction
      pulse_fault(3'b001);
      trst_n = 1'b0;
      #1;
      chk("R1 oe during trst", {31'b0, tdo_oe}, 32'd0);
      trst_n = 1'b1;
      step(1'b0, 1'b0);
      scan_dr(32'h1234_5678, drv);
      chk("R1 idcode after trst", drv, ID_EXP);
      load_ir(5'b00010, 3'b000, 3'b000, irv);
      chk("R5 flags cleared by trst", {27'b0, irv}, {27'b0, CAP_OK});

      // five tms-high edges return to reset and reload idcode
      ucode = 32'h8001_0420;
      for (int k = 0; k < 5; k++) step(1'b1, 1'b0);
      step(1'b0, 1'b0);
      scan_dr(32'h0, drv);
      chk("R2 five ones reload idcode", drv, ID_EXP);

      chk("R11 oe high while shifting", oe_bad, 32'd0);
      chk("R11 oe low after shifts", {31'b0, tdo_oe}, 32'd0);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule